// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces operand addresses for indirect memory accesses. It holds a small bank of pointer registers and a bank of modify registers. On each access the caller picks one pointer and one modify register. The block reports the pointer's current value as the address, then moves the pointer by the chosen modify amount. This is the post-modify scheme.

Each pointer has its own length register and a base that is captured when the pointer is written. A zero length gives plain linear stepping, which wraps only at the edge of the 14-bit address space. A nonzero length keeps the pointer inside the ring that starts at the base and spans length words. A processor core normally places two copies side by side, one for the data-memory operand and one for the program-memory operand, so that both can be fetched in the same cycle.

Top module: `cbuf_agen`

## Requirements
- R1: While `rst` is high, `addr_vld` and `addr_out` read 0 on the following cycle, and every pointer, base, length and modify register returns to 0.
- R2: An access (`acc_en` high at a rising edge) raises `addr_vld` for exactly the next cycle, with `addr_out` equal to the selected pointer's value before that access.
- R3: With the selected pointer's length at 0, the pointer becomes pointer plus modify, taken modulo 2^14, so a step past 0x3FFF lands at the low end of the space.
- R4: Modify values are 14-bit two's complement, so a modify of 0x3FFE moves the pointer down by 2.
- R5: With a nonzero length L and base B, an updated value at or above B+L has L subtracted.
- R6: With a nonzero length L and base B, an updated value below B has L added.
- R7: Writing a pointer also sets that pointer's base to the written value. Writing a length leaves the base and the pointer unchanged.
- R8: Any of the four modify registers can be used with any of the four pointers on any access.
- R9: When a pointer write and an access to the same pointer share a cycle, `addr_out` shows the old value, and the pointer then holds the written value.
- R10: A pointer write to one entry in the same cycle as an access to another entry affects only the written entry. The accessed entry still steps normally.
- R11: A cycle without an access leaves `addr_vld` low on the next cycle and leaves all pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ptr_we | input | 1 | Pointer write enable (also loads the base) |
| ptr_wsel | input | 2 | Pointer write index |
| ptr_wdata | input | 14 | Pointer write value |
| len_we | input | 1 | Length write enable |
| len_wsel | input | 2 | Length write index |
| len_wdata | input | 14 | Length value, 0 means linear |
| mod_we | input | 1 | Modify register write enable |
| mod_wsel | input | 2 | Modify register write index |
| mod_wdata | input | 14 | Modify value, two's complement |
| acc_en | input | 1 | Access request |
| acc_psel | input | 2 | Pointer used by the access |
| acc_msel | input | 2 | Modify register used by the access |
| addr_out | output | 14 | Address produced by the last access |
| addr_vld | output | 1 | High for the cycle after an access |

## Verification
Two situations are the hardest to reach from the ports. The first is a ring pointer that crosses the top end and then the bottom end. The stimulus uses short lengths (4 to 9 words) with modify steps that are close to the length, so a few consecutive accesses push the pointer past each end. The second is a collision of a write and an access on the same pointer. A single driven cycle raises the pointer write and the access together, and the access that follows shows whether the written value won. A reset issued in the middle of the run, followed by fresh accesses, shows that every register bank was cleared.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    localparam int AGEN_AW   = 14;
    localparam int AGEN_NPTR = 4;
    localparam int AGEN_NMOD = 4;

    typedef logic [AGEN_AW-1:0] agen_addr_t;
    typedef logic signed [AGEN_AW+1:0] agen_wide_t;

    // Ring description kept per pointer
    typedef struct packed {
        agen_addr_t base;
        agen_addr_t len;
    } agen_ring_t;

    // What happens to one pointer entry in a cycle
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_STEP = 2'd1,
        UPD_LOAD = 2'd2
    } agen_upd_e;

    function automatic agen_wide_t agen_zext(input agen_addr_t v);
        return agen_wide_t'({2'b00, v});
    endfunction

    function automatic agen_wide_t agen_sext(input agen_addr_t v);
        return agen_wide_t'({{2{v[AGEN_AW-1]}}, v});
    endfunction

    function automatic agen_addr_t agen_trunc(input agen_wide_t v);
        return v[AGEN_AW-1:0];
    endfunction

endpackage

// File: rtl/cbuf_mod_bank.sv
module cbuf_mod_bank
    import cbuf_pkg::*;
#(
    parameter int NMOD = AGEN_NMOD,
    localparam int MSW = $clog2(NMOD)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [MSW-1:0]               wr_sel,
    input  agen_addr_t                   wr_data,
    output logic [NMOD-1:0][AGEN_AW-1:0] mod_o
);

    for (genvar i = 0; i < NMOD; i++) begin : g_mod
        logic hit;
        assign hit = wr_en && (wr_sel == MSW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                mod_o[i] <= '0;
            end else if (hit) begin
                mod_o[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/cbuf_ptr_bank.sv
module cbuf_ptr_bank
    import cbuf_pkg::*;
#(
    parameter int NPTR = AGEN_NPTR,
    localparam int PSW = $clog2(NPTR)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [PSW-1:0]               wr_sel,
    input  agen_addr_t                   wr_data,
    input  logic                         len_en,
    input  logic [PSW-1:0]               len_sel,
    input  agen_addr_t                   len_data,
    input  logic                         upd_en,
    input  logic [PSW-1:0]               upd_sel,
    input  agen_addr_t                   upd_val,
    output logic [NPTR-1:0][AGEN_AW-1:0] ptr_o,
    output logic [NPTR-1:0][AGEN_AW-1:0] base_o,
    output logic [NPTR-1:0][AGEN_AW-1:0] len_o
);

    for (genvar i = 0; i < NPTR; i++) begin : g_ent
        agen_addr_t ptr_q;
        agen_ring_t ring_q;
        agen_upd_e  act;

        // A register write outranks the post-modify update
        always_comb begin
            if (wr_en && (wr_sel == PSW'(i))) begin
                act = UPD_LOAD;
            end else if (upd_en && (upd_sel == PSW'(i))) begin
                act = UPD_STEP;
            end else begin
                act = UPD_HOLD;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q <= '0;
            end else begin
                case (act)
                    UPD_LOAD: ptr_q <= wr_data;
                    UPD_STEP: ptr_q <= upd_val;
                    default:  ptr_q <= ptr_q;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ring_q <= '0;
            end else begin
                if (act == UPD_LOAD) begin
                    ring_q.base <= wr_data;
                end
                if (len_en && (len_sel == PSW'(i))) begin
                    ring_q.len <= len_data;
                end
            end
        end

        assign ptr_o[i]  = ptr_q;
        assign base_o[i] = ring_q.base;
        assign len_o[i]  = ring_q.len;
    end

endmodule

// File: rtl/cbuf_wrap_unit.sv
module cbuf_wrap_unit
    import cbuf_pkg::*;
(
    input  agen_addr_t cur,
    input  agen_addr_t step,
    input  agen_ring_t ring,
    output agen_addr_t nxt
);

    agen_wide_t sum;
    agen_wide_t lo;
    agen_wide_t hi;
    agen_wide_t fixed;
    logic       linear;
    logic       over;
    logic       under;

    always_comb begin
        sum    = agen_zext(cur) + agen_sext(step);
        lo     = agen_zext(ring.base);
        hi     = lo + agen_zext(ring.len);
        linear = (ring.len == '0);
        over   = (sum >= hi);
        under  = (sum < lo);

        if (linear) begin
            fixed = sum;
        end else if (over) begin
            fixed = sum - agen_zext(ring.len);
        end else if (under) begin
            fixed = sum + agen_zext(ring.len);
        end else begin
            fixed = sum;
        end

        nxt = agen_trunc(fixed);
    end

endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
    import cbuf_pkg::*;
#(
    parameter int NPTR = AGEN_NPTR,
    parameter int NMOD = AGEN_NMOD,
    localparam int PSW = $clog2(NPTR),
    localparam int MSW = $clog2(NMOD),
    localparam int AW  = AGEN_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ptr_we,
    input  logic [PSW-1:0] ptr_wsel,
    input  logic [AW-1:0]  ptr_wdata,
    input  logic           len_we,
    input  logic [PSW-1:0] len_wsel,
    input  logic [AW-1:0]  len_wdata,
    input  logic           mod_we,
    input  logic [MSW-1:0] mod_wsel,
    input  logic [AW-1:0]  mod_wdata,
    input  logic           acc_en,
    input  logic [PSW-1:0] acc_psel,
    input  logic [MSW-1:0] acc_msel,
    output logic [AW-1:0]  addr_out,
    output logic           addr_vld
);

    logic [NPTR-1:0][AW-1:0] ptr_all;
    logic [NPTR-1:0][AW-1:0] base_all;
    logic [NPTR-1:0][AW-1:0] len_all;
    logic [NMOD-1:0][AW-1:0] mod_all;

    agen_addr_t cur_ptr;
    agen_addr_t cur_mod;
    agen_ring_t cur_ring;
    agen_addr_t next_ptr;

    cbuf_ptr_bank #(.NPTR(NPTR)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ptr_we),
        .wr_sel   (ptr_wsel),
        .wr_data  (ptr_wdata),
        .len_en   (len_we),
        .len_sel  (len_wsel),
        .len_data (len_wdata),
        .upd_en   (acc_en),
        .upd_sel  (acc_psel),
        .upd_val  (next_ptr),
        .ptr_o    (ptr_all),
        .base_o   (base_all),
        .len_o    (len_all)
    );

    cbuf_mod_bank #(.NMOD(NMOD)) u_mods (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mod_we),
        .wr_sel  (mod_wsel),
        .wr_data (mod_wdata),
        .mod_o   (mod_all)
    );

    always_comb begin
        cur_ptr       = ptr_all[acc_psel];
        cur_mod       = mod_all[acc_msel];
        cur_ring.base = base_all[acc_psel];
        cur_ring.len  = len_all[acc_psel];
    end

    cbuf_wrap_unit u_wrap (
        .cur  (cur_ptr),
        .step (cur_mod),
        .ring (cur_ring),
        .nxt  (next_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_out <= '0;
            addr_vld <= 1'b0;
        end else begin
            addr_vld <= acc_en;
            if (acc_en) begin
                addr_out <= cur_ptr;
            end
        end
    end

endmodule

// File: rtl/cbuf_agen_chk.sv
module cbuf_agen_chk
    import cbuf_pkg::*;
#(
    parameter int NPTR = AGEN_NPTR,
    parameter int NMOD = AGEN_NMOD,
    localparam int PSW = $clog2(NPTR),
    localparam int MSW = $clog2(NMOD),
    localparam int AW  = AGEN_AW
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ptr_we,
    input logic [PSW-1:0]          ptr_wsel,
    input logic [AW-1:0]           ptr_wdata,
    input logic                    len_we,
    input logic                    acc_en,
    input logic [PSW-1:0]          acc_psel,
    input logic [MSW-1:0]          acc_msel,
    input logic [AW-1:0]           addr_out,
    input logic                    addr_vld,
    input logic [NPTR-1:0][AW-1:0] ptr_q,
    input logic [NPTR-1:0][AW-1:0] base_q,
    input logic [NPTR-1:0][AW-1:0] len_q,
    input logic [NMOD-1:0][AW-1:0] mod_q
);

    logic [AW-1:0]  sel_ptr, sel_mod, sel_base, sel_len, sel_mag, lin_next;
    logic [PSW-1:0] ws_d, ps_d;
    logic           collide, sel_in_ring, post_in_ring;

    always_comb begin
        sel_ptr  = ptr_q[acc_psel];
        sel_mod  = mod_q[acc_msel];
        sel_base = base_q[acc_psel];
        sel_len  = len_q[acc_psel];
        sel_mag  = sel_mod[AW-1] ? (~sel_mod + 1'b1) : sel_mod;
        lin_next = sel_ptr + sel_mod;
        collide  = ptr_we && (ptr_wsel == acc_psel);
        sel_in_ring = ({1'b0, sel_ptr} >= {1'b0, sel_base}) &&
                      ({1'b0, sel_ptr} < ({1'b0, sel_base} + {1'b0, sel_len}));
        post_in_ring = ({1'b0, ptr_q[ps_d]} >= {1'b0, base_q[ps_d]}) &&
                       ({1'b0, ptr_q[ps_d]} < ({1'b0, base_q[ps_d]} + {1'b0, len_q[ps_d]}));
    end

    always_ff @(posedge clk) begin
        ws_d <= ptr_wsel;
        ps_d <= acc_psel;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!addr_vld && addr_out == '0));

    // R2
    access_reports_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> (addr_vld && addr_out == $past(sel_ptr)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> !addr_vld);

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_we |=> (ptr_q[ws_d] == $past(ptr_wdata)));

    // R7
    base_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_we |=> (base_q[ws_d] == $past(ptr_wdata)));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !collide && sel_len == '0) |=> (ptr_q[ps_d] == $past(lin_next)));

    // R5
    ring_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !collide && !len_we && sel_len != '0 && sel_in_ring && sel_mag < sel_len)
        |=> post_in_ring);

endmodule

bind cbuf_agen cbuf_agen_chk #(.NPTR(NPTR), .NMOD(NMOD)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ptr_we    (ptr_we),
    .ptr_wsel  (ptr_wsel),
    .ptr_wdata (ptr_wdata),
    .len_we    (len_we),
    .acc_en    (acc_en),
    .acc_psel  (acc_psel),
    .acc_msel  (acc_msel),
    .addr_out  (addr_out),
    .addr_vld  (addr_vld),
    .ptr_q     (ptr_all),
    .base_q    (base_all),
    .len_q     (len_all),
    .mod_q     (mod_all)
);

// File: tb/cbuf_agen_test.sv
`timescale 1ns/1ps
module cbuf_agen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ptr_we = 1'b0, len_we = 1'b0, mod_we = 1'b0, acc_en = 1'b0;
    logic [1:0]  ptr_wsel = '0, len_wsel = '0, mod_wsel = '0, acc_psel = '0, acc_msel = '0;
    logic [13:0] ptr_wdata = '0, len_wdata = '0, mod_wdata = '0;
    logic [13:0] addr_out;
    logic        addr_vld;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // Model state
    logic [13:0] mp [4];
    logic [13:0] mb [4];
    logic [13:0] ml [4];
    logic [13:0] mm [4];

    // Scoreboard queues
    bit          q_vld  [$];
    logic [13:0] q_addr [$];
    string       q_tag  [$];

    always #4 clk = ~clk;

    cbuf_agen uut (
        .clk(clk), .rst(rst),
        .ptr_we(ptr_we), .ptr_wsel(ptr_wsel), .ptr_wdata(ptr_wdata),
        .len_we(len_we), .len_wsel(len_wsel), .len_wdata(len_wdata),
        .mod_we(mod_we), .mod_wsel(mod_wsel), .mod_wdata(mod_wdata),
        .acc_en(acc_en), .acc_psel(acc_psel), .acc_msel(acc_msel),
        .addr_out(addr_out), .addr_vld(addr_vld)
    );

    function automatic logic [13:0] model_next(logic [13:0] p, logic [13:0] m,
                                               logic [13:0] b, logic [13:0] l);
        int s;
        if (l == 14'd0) return p + m;
        s = int'(p) + (m[13] ? int'(m) - 16384 : int'(m));
        if (s >= int'(b) + int'(l)) s = s - int'(l);
        else if (s < int'(b)) s = s + int'(l);
        return s[13:0];
    endfunction

    task automatic step(input bit r, input bit acc, input int p, input int m,
                        input bit pw, input int pws, input logic [13:0] pwd,
                        input bit lw, input int lws, input logic [13:0] lwd,
                        input bit mw, input int mws, input logic [13:0] mwd,
                        input string tag);
        @(negedge clk);
        rst = r; acc_en = acc; acc_psel = 2'(p); acc_msel = 2'(m);
        ptr_we = pw; ptr_wsel = 2'(pws); ptr_wdata = pwd;
        len_we = lw; len_wsel = 2'(lws); len_wdata = lwd;
        mod_we = mw; mod_wsel = 2'(mws); mod_wdata = mwd;
        if (r) begin
            for (int i = 0; i < 4; i++) begin
                mp[i] = '0; mb[i] = '0; ml[i] = '0; mm[i] = '0;
            end
            q_vld.push_back(1'b0); q_addr.push_back(14'd0); q_tag.push_back("R1");
        end else begin
            if (acc) begin
                q_vld.push_back(1'b1); q_addr.push_back(mp[p]); q_tag.push_back(tag);
                mp[p] = model_next(mp[p], mm[m], mb[p], ml[p]);
            end else begin
                q_vld.push_back(1'b0); q_addr.push_back(14'd0); q_tag.push_back(tag);
            end
            if (pw) begin mp[pws] = pwd; mb[pws] = pwd; end
            if (lw) ml[lws] = lwd;
            if (mw) mm[mws] = mwd;
        end
    endtask

    task automatic acc(input int p, input int m, input string tag);
        step(0, 1, p, m, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic wptr(input int s, input logic [13:0] d);
        step(0, 0, 0, 0, 1, s, d, 0, 0, 0, 0, 0, 0, "R7");
    endtask
    task automatic wlen(input int s, input logic [13:0] d);
        step(0, 0, 0, 0, 0, 0, 0, 1, s, d, 0, 0, 0, "R7");
    endtask
    task automatic wmod(input int s, input logic [13:0] d);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, s, d, "R8");
    endtask
    task automatic do_reset();
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    endtask

    // Monitor: one expected item per driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_vld.size() > 0) begin
                bit          ev;
                logic [13:0] ea;
                string       et;
                bit          ok;
                ev = q_vld.pop_front();
                ea = q_addr.pop_front();
                et = q_tag.pop_front();
                if (ev) ok = addr_vld && (addr_out == ea);
                else if (et == "R1") ok = !addr_vld && (addr_out == 14'd0);
                else ok = !addr_vld;
                total++;
                if (!ok) begin
                    bad++;
                    $display("FAIL %s: vld=%0b addr=%h expected vld=%0b addr=%h",
                             et, addr_vld, addr_out, ev, ea);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: vld=%0b addr=%h expected run end", addr_vld, addr_out);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(); do_reset(); do_reset();
        idle("R11");

        wmod(0, 14'd1); wmod(1, 14'd3); wmod(2, 14'h3FFE); wmod(3, 14'd5);

        // R2 R3 R8 linear stepping, different modify registers
        wptr(0, 14'h0100);
        acc(0, 0, "R2"); acc(0, 1, "R8"); acc(0, 3, "R3"); acc(0, 2, "R4");

        // R3 wrap at the top of the address space
        wptr(1, 14'h3FFE);
        acc(1, 1, "R3"); acc(1, 1, "R3");

        // R4 negative modify, linear, below zero
        wptr(2, 14'h0001);
        acc(2, 2, "R4"); acc(2, 2, "R4"); acc(2, 2, "R4");

        // R5 circular, crossing the top of the ring
        wptr(3, 14'h0200); wlen(3, 14'd5);
        for (int k = 0; k < 6; k++) acc(3, 1, "R5");

        // R6 circular, crossing the bottom of the ring
        wptr(0, 14'h0300); wlen(0, 14'd4);
        for (int k = 0; k < 5; k++) acc(0, 2, "R6");

        // R7 length write keeps base; pointer write moves base
        wlen(3, 14'd6);
        for (int k = 0; k < 4; k++) acc(3, 3, "R7");
        wptr(3, 14'h0210);
        for (int k = 0; k < 4; k++) acc(3, 3, "R7");

        // R11 idle cycles change nothing
        idle("R11"); idle("R11");
        acc(3, 0, "R11");

        // R9 write and access on the same pointer in one cycle
        step(0, 1, 1, 1, 1, 1, 14'h0555, 0, 0, 0, 0, 0, 0, "R9");
        acc(1, 0, "R9"); acc(1, 0, "R9");

        // R10 write one pointer while accessing another
        step(0, 1, 2, 3, 1, 0, 14'h0777, 0, 0, 0, 0, 0, 0, "R10");
        acc(2, 0, "R10"); acc(0, 0, "R10");

        // R8 mixed selections over linear and ring pointers
        wlen(0, 14'd0); wlen(1, 14'd0);
        wptr(2, 14'h0040); wlen(2, 14'd7);
        wptr(3, 14'h1000); wlen(3, 14'd9);
        for (int k = 0; k < 40; k++) acc(k % 4, (k * 3 + k / 4) % 4, "R8");

        // R1 reset mid-run clears everything
        do_reset();
        acc(0, 0, "R1"); acc(2, 3, "R1"); acc(0, 0, "R1");

        idle("R11"); idle("R11");
        @(posedge clk); #2;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule